// File: doc/BRIEF.md
# Instruction Operand Addressing Decoder

This block takes one 16-bit instruction word and decodes it. It sorts the word into one of three instruction groups or marks it illegal. It extracts the opcode, register numbers, byte/word flag and addressing modes. It also works out the following operand-fetch facts:

- whether a hard-wired constant replaces the operand;
- whether absolute addressing applies;
- how many extension words follow the instruction, and which operand each one serves;
- how far an auto-incremented register must step.

Words enter on a valid/ready stream and leave one cycle later on a second valid/ready stream. One register stage sits between the two streams. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output field holds its value and no new word is taken.

The block does not fetch memory and holds no register file. It only describes what the fetch logic must do next.

Top module: `opd_addr_decoder`

## Requirements
- R1: Group encoding on `out_class`: a word with bits [15:13]=001 is a jump (3). A word with bits [15:14] not 00 is double-operand (1). A word with bits [15:10]=000100 is single-operand (2). Every other word is illegal (0).
- R2: Double-operand fields are:
  - opcode = bits [15:12];
  - source register = [11:8];
  - destination mode = {0, bit 7}, where 0 is direct and 1 is indexed;
  - byte flag = bit 6;
  - source mode = [5:4];
  - destination register = [3:0].
- R3: Single-operand fields are opcode = {0, bits [9:7]}, byte flag = bit 6, operand mode = [5:4] and operand register = [3:0]. The operand mode and register are reported as the destination, and the source fields read zero.
- R4: Jump fields are condition = bits [12:10] and offset = bits [9:0]. For non-jump words both fields read zero.
- R5: When register 3 is the constant-checked operand, `out_cg_sel` is 1. The value is 0, 1, 2 or 0xFFFF for mode 00, 01, 10 or 11 respectively, and no extension word is counted for that operand. The constant-checked operand is the source of a double-operand word, or the sole operand of a single-operand word.
- R6: When register 2 is the constant-checked operand:
  - mode 00 is a plain register access with no constant;
  - mode 01 is absolute addressing, which raises the abs flag and uses one extension word;
  - mode 10 yields the constant 4;
  - mode 11 yields the constant 8.
  A double-operand destination on register 2 in indexed mode raises `out_abs_dst`.
- R7: The extension-word count is the sum of the following, each counted once:
  - one for a mode-01 operand on any register other than 3;
  - one for mode 11 on register 0 (an immediate);
  - one for an indexed double-operand destination.
- R8: Extension words are ordered source first, then destination. The role codes are 0 none, 1 source and 2 destination. `out_ext0_role` names the first word and `out_ext1_role` the second. A single-operand word's extension word has role 2.
- R9: For mode 11 without a constant, `out_inc_step` is 2 on registers 0 and 1 and in word mode. It is 1 in byte mode on any other register. In all other cases it is 0.
- R10: The output appears on the first clock edge after acceptance. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs hold.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.
- R12: Jump and illegal words report zero registers, modes, constant select, abs flags, extension count, roles and increment step. An illegal word also reports opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 2 | 0 illegal, 1 double, 2 single, 3 jump |
| out_opcode | output | 4 | Opcode |
| out_cond | output | 3 | Jump condition |
| out_offset | output | 10 | Jump offset |
| out_byte | output | 1 | Byte-mode flag |
| out_sreg | output | 4 | Source register |
| out_dreg | output | 4 | Destination / sole operand register |
| out_smode | output | 2 | Source mode |
| out_dmode | output | 2 | Destination / sole operand mode |
| out_cg_sel | output | 1 | Operand replaced by a constant |
| out_cg_value | output | 16 | Constant value |
| out_abs_src | output | 1 | Source uses absolute addressing |
| out_abs_dst | output | 1 | Destination uses absolute addressing |
| out_ext_count | output | 2 | Extension words following |
| out_ext0_role | output | 2 | Role of first extension word |
| out_ext1_role | output | 2 | Role of second extension word |
| out_inc_step | output | 2 | Post-increment amount |

## Verification
The hardest situation to reach from the ports is a stalled result while a second word is already waiting. In that state the output must stay frozen and the waiting word must not slip in. The bench builds it with a directed sequence: it drops `out_ready`, offers a second word during the stall, and then releases the stall. A second rare case is an operand on registers 0 to 3 in exactly the mode that triggers a constant, an immediate or absolute addressing. To reach it often, the random stimulus builds words from chosen group prefixes, and half the time it draws the register fields from that low range.

// File: rtl/opd_pkg.sv
package opd_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 4;
  localparam int MODE_W = 2;
  localparam int OPC_W  = 4;
  localparam int COND_W = 3;
  localparam int OFS_W  = 10;
  localparam int CNT_W  = 2;
  localparam int STEP_W = 2;

  localparam logic [REG_W-1:0] REG_PC = 4'd0;
  localparam logic [REG_W-1:0] REG_SP = 4'd1;
  localparam logic [REG_W-1:0] REG_SR = 4'd2;
  localparam logic [REG_W-1:0] REG_CG = 4'd3;

  localparam logic [MODE_W-1:0] M_DIR = 2'b00;
  localparam logic [MODE_W-1:0] M_IDX = 2'b01;
  localparam logic [MODE_W-1:0] M_IND = 2'b10;
  localparam logic [MODE_W-1:0] M_INC = 2'b11;

  typedef enum logic [1:0] {
    FMT_ILLEGAL = 2'd0,
    FMT_DOUBLE  = 2'd1,
    FMT_SINGLE  = 2'd2,
    FMT_JUMP    = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_SRC  = 2'd1,
    EXT_DST  = 2'd2
  } role_e;

  typedef struct packed {
    fmt_e               fmt;
    logic [OPC_W-1:0]   opcode;
    logic [COND_W-1:0]  cond;
    logic [OFS_W-1:0]   offset;
    logic               byte_op;
    logic [REG_W-1:0]   sreg;
    logic [REG_W-1:0]   dreg;
    logic [MODE_W-1:0]  smode;
    logic [MODE_W-1:0]  dmode;
    logic               cg_sel;
    logic [WORD_W-1:0]  cg_val;
    logic               abs_src;
    logic               abs_dst;
    logic [CNT_W-1:0]   ext_cnt;
    role_e              role0;
    role_e              role1;
    logic [STEP_W-1:0]  inc_step;
  } dec_t;
endpackage

// File: rtl/opd_fmt_split.sv
module opd_fmt_split
  import opd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   word,
  output fmt_e                fmt,
  output logic [OPC_W-1:0]    opcode,
  output logic [COND_W-1:0]   cond,
  output logic [OFS_W-1:0]    offset,
  output logic                byte_op,
  output logic [REG_W-1:0]    sreg,
  output logic [REG_W-1:0]    dreg,
  output logic [MODE_W-1:0]   smode,
  output logic [MODE_W-1:0]   dmode
);
  always_comb begin
    fmt     = FMT_ILLEGAL;
    opcode  = '0;
    cond    = '0;
    offset  = '0;
    byte_op = 1'b0;
    sreg    = '0;
    dreg    = '0;
    smode   = '0;
    dmode   = '0;
    if (word[15:13] == 3'b001) begin
      fmt    = FMT_JUMP;
      cond   = word[12:10];
      offset = word[9:0];
    end else if (word[15:14] != 2'b00) begin
      fmt     = FMT_DOUBLE;
      opcode  = word[15:12];
      sreg    = word[11:8];
      dmode   = {1'b0, word[7]};
      byte_op = word[6];
      smode   = word[5:4];
      dreg    = word[3:0];
    end else if (word[15:10] == 6'b000100) begin
      fmt     = FMT_SINGLE;
      opcode  = {1'b0, word[9:7]};
      byte_op = word[6];
      dmode   = word[5:4];
      dreg    = word[3:0];
    end
  end

  // R1: a jump class is only ever reported for the 001 prefix
  assert_jump_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_JUMP) |-> (word[15:13] == 3'b001));
  // R3: single-operand group never carries a source mode
  assert_single_nosrc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_SINGLE) |-> (smode == '0 && sreg == '0));
endmodule

// File: rtl/opd_operand.sv
module opd_operand
  import opd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [REG_W-1:0]   rnum,
  input  logic [MODE_W-1:0]  mode,
  input  logic               byte_op,
  output logic               cg_sel,
  output logic [WORD_W-1:0]  cg_val,
  output logic               abs_hit,
  output logic               ext_need,
  output logic [STEP_W-1:0]  inc_step
);
  logic is_sr, is_cg, full_step;

  assign is_sr     = (rnum == REG_SR);
  assign is_cg     = (rnum == REG_CG);
  assign full_step = !byte_op || rnum == REG_PC || rnum == REG_SP;

  always_comb begin
    cg_sel = active && (is_cg || (is_sr && mode[1]));
    cg_val = '0;
    if (cg_sel) begin
      if (is_cg) begin
        unique case (mode)
          M_DIR:   cg_val = '0;
          M_IDX:   cg_val = WORD_W'(1);
          M_IND:   cg_val = WORD_W'(2);
          default: cg_val = '1;
        endcase
      end else begin
        cg_val = (mode == M_IND) ? WORD_W'(4) : WORD_W'(8);
      end
    end
  end

  assign abs_hit  = active && is_sr && (mode == M_IDX);
  assign ext_need = active && !cg_sel &&
                    ((mode == M_IDX) || (mode == M_INC && rnum == REG_PC));
  assign inc_step = (active && !cg_sel && mode == M_INC)
                    ? (full_step ? STEP_W'(2) : STEP_W'(1)) : '0;

  // R5: a constant never consumes an extension word
  assert_cg_noext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> !ext_need);
  // R9: only post-increment mode steps the register
  assert_inc_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_step != '0) |-> (mode == M_INC && !cg_sel));
  // R6: absolute addressing always brings one extension word
  assert_abs_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abs_hit |-> ext_need);
endmodule

// File: rtl/opd_ext_order.sv
module opd_ext_order
  import opd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ext,
  input  logic              dst_ext,
  output logic [CNT_W-1:0]  cnt,
  output role_e             role0,
  output role_e             role1
);
  assign cnt = CNT_W'(src_ext) + CNT_W'(dst_ext);

  always_comb begin
    role0 = EXT_NONE;
    role1 = EXT_NONE;
    if (src_ext) begin
      role0 = EXT_SRC;
      if (dst_ext) role1 = EXT_DST;
    end else if (dst_ext) begin
      role0 = EXT_DST;
    end
  end

  // R8: with two extension words the source one always comes first
  assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(2)) |-> (role0 == EXT_SRC && role1 == EXT_DST));
  // R7: no role is named for a word that is not counted
  assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (role0 == EXT_NONE && role1 == EXT_NONE));
endmodule

// File: rtl/opd_addr_decoder.sv
module opd_addr_decoder
  import opd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_class,
  output logic [OPC_W-1:0]   out_opcode,
  output logic [COND_W-1:0]  out_cond,
  output logic [OFS_W-1:0]   out_offset,
  output logic               out_byte,
  output logic [REG_W-1:0]   out_sreg,
  output logic [REG_W-1:0]   out_dreg,
  output logic [MODE_W-1:0]  out_smode,
  output logic [MODE_W-1:0]  out_dmode,
  output logic               out_cg_sel,
  output logic [WORD_W-1:0]  out_cg_value,
  output logic               out_abs_src,
  output logic               out_abs_dst,
  output logic [CNT_W-1:0]   out_ext_count,
  output logic [1:0]         out_ext0_role,
  output logic [1:0]         out_ext1_role,
  output logic [STEP_W-1:0]  out_inc_step
);
  fmt_e               fmt;
  logic [OPC_W-1:0]   opcode;
  logic [COND_W-1:0]  cond;
  logic [OFS_W-1:0]   offset;
  logic               byte_op;
  logic [REG_W-1:0]   sreg, dreg, op_reg;
  logic [MODE_W-1:0]  smode, dmode, op_mode;
  logic               is_dbl, op_active;
  logic               cg_sel, abs_hit, op_ext;
  logic [WORD_W-1:0]  cg_val;
  logic [STEP_W-1:0]  inc_step;
  logic [CNT_W-1:0]   ext_cnt;
  role_e              role0, role1;
  dec_t               dec_d, dec_q;

  opd_fmt_split u_split (
    .clk(clk), .rst_n(rst_n), .word(in_word), .fmt(fmt), .opcode(opcode),
    .cond(cond), .offset(offset), .byte_op(byte_op), .sreg(sreg),
    .dreg(dreg), .smode(smode), .dmode(dmode)
  );

  assign is_dbl    = (fmt == FMT_DOUBLE);
  assign op_active = is_dbl || (fmt == FMT_SINGLE);
  assign op_reg    = is_dbl ? sreg  : dreg;
  assign op_mode   = is_dbl ? smode : dmode;

  opd_operand u_opnd (
    .clk(clk), .rst_n(rst_n), .active(op_active), .rnum(op_reg),
    .mode(op_mode), .byte_op(byte_op), .cg_sel(cg_sel), .cg_val(cg_val),
    .abs_hit(abs_hit), .ext_need(op_ext), .inc_step(inc_step)
  );

  opd_ext_order u_order (
    .clk(clk), .rst_n(rst_n),
    .src_ext(is_dbl && op_ext),
    .dst_ext(is_dbl ? dmode[0] : op_ext),
    .cnt(ext_cnt), .role0(role0), .role1(role1)
  );

  always_comb begin
    dec_d.fmt      = fmt;
    dec_d.opcode   = opcode;
    dec_d.cond     = cond;
    dec_d.offset   = offset;
    dec_d.byte_op  = byte_op;
    dec_d.sreg     = sreg;
    dec_d.dreg     = dreg;
    dec_d.smode    = smode;
    dec_d.dmode    = dmode;
    dec_d.cg_sel   = cg_sel;
    dec_d.cg_val   = cg_val;
    dec_d.abs_src  = is_dbl && abs_hit;
    dec_d.abs_dst  = is_dbl ? (dmode[0] && dreg == REG_SR) : abs_hit;
    dec_d.ext_cnt  = ext_cnt;
    dec_d.role0    = role0;
    dec_d.role1    = role1;
    dec_d.inc_step = inc_step;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dec_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) dec_q <= dec_d;
    end
  end

  assign out_class     = dec_q.fmt;
  assign out_opcode    = dec_q.opcode;
  assign out_cond      = dec_q.cond;
  assign out_offset    = dec_q.offset;
  assign out_byte      = dec_q.byte_op;
  assign out_sreg      = dec_q.sreg;
  assign out_dreg      = dec_q.dreg;
  assign out_smode     = dec_q.smode;
  assign out_dmode     = dec_q.dmode;
  assign out_cg_sel    = dec_q.cg_sel;
  assign out_cg_value  = dec_q.cg_val;
  assign out_abs_src   = dec_q.abs_src;
  assign out_abs_dst   = dec_q.abs_dst;
  assign out_ext_count = dec_q.ext_cnt;
  assign out_ext0_role = dec_q.role0;
  assign out_ext1_role = dec_q.role1;
  assign out_inc_step  = dec_q.inc_step;

  // R10: a stalled result stays valid and unchanged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dec_q)));
  // R12: jumps and illegal words carry no operand work
  assert_nooperand_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_class == 2'd0 || out_class == 2'd3)) |->
      (out_ext_count == '0 && !out_cg_sel && out_inc_step == '0));
endmodule

// File: tb/test_opd_addr_decoder.sv
module test_opd_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_class;
  logic [3:0]  out_opcode;
  logic [2:0]  out_cond;
  logic [9:0]  out_offset;
  logic        out_byte;
  logic [3:0]  out_sreg, out_dreg;
  logic [1:0]  out_smode, out_dmode;
  logic        out_cg_sel;
  logic [15:0] out_cg_value;
  logic        out_abs_src, out_abs_dst;
  logic [1:0]  out_ext_count, out_ext0_role, out_ext1_role, out_inc_step;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opd_addr_decoder i_opd_addr_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_opcode(out_opcode), .out_cond(out_cond),
    .out_offset(out_offset), .out_byte(out_byte), .out_sreg(out_sreg),
    .out_dreg(out_dreg), .out_smode(out_smode), .out_dmode(out_dmode),
    .out_cg_sel(out_cg_sel), .out_cg_value(out_cg_value),
    .out_abs_src(out_abs_src), .out_abs_dst(out_abs_dst),
    .out_ext_count(out_ext_count), .out_ext0_role(out_ext0_role),
    .out_ext1_role(out_ext1_role), .out_inc_step(out_inc_step)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp,
                     input logic [15:0] w);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s word=%h actual=%h expected=%h", req, what, w, act, exp);
    end
  endtask

  // expected operand behaviour for one register/mode pair
  function automatic void ref_opnd(input logic [3:0] r, input logic [1:0] m,
      input logic bw, output logic sel, output logic [15:0] v,
      output logic ext, output logic [1:0] inc, output logic ab);
    sel = 0; v = 0; ext = 0; inc = 0; ab = 0;
    if (r == 4'd3) begin
      sel = 1;
      case (m)
        2'd0: v = 16'h0000;
        2'd1: v = 16'h0001;
        2'd2: v = 16'h0002;
        default: v = 16'hFFFF;
      endcase
    end else if (r == 4'd2) begin
      case (m)
        2'd1: begin ab = 1; ext = 1; end
        2'd2: begin sel = 1; v = 16'd4; end
        2'd3: begin sel = 1; v = 16'd8; end
        default: ;
      endcase
    end else begin
      if (m == 2'd1) ext = 1;
      if (m == 2'd3) begin
        inc = (bw && r > 4'd1) ? 2'd1 : 2'd2;
        if (r == 4'd0) ext = 1;
      end
    end
  endfunction

  task automatic check_word(input logic [15:0] w);
    logic [1:0] cls; logic [3:0] opc, sr, dr; logic [2:0] cd; logic [9:0] of;
    logic bw, sel, ext, ab, dx, abd, abs_s; logic [1:0] sm, dm, inc, cnt, r0, r1;
    logic [15:0] v;
    cls = 0; opc = 0; sr = 0; dr = 0; cd = 0; of = 0; bw = 0; sm = 0; dm = 0;
    sel = 0; v = 0; ext = 0; inc = 0; ab = 0; dx = 0; abd = 0; abs_s = 0;
    if (w[15:13] == 3'b001) begin
      cls = 3; cd = w[12:10]; of = w[9:0];
    end else if (w[15:12] >= 4'd4) begin
      cls = 1; opc = w[15:12]; sr = w[11:8]; dm = {1'b0, w[7]}; bw = w[6];
      sm = w[5:4]; dr = w[3:0];
      ref_opnd(sr, sm, bw, sel, v, ext, inc, ab);
      dx = w[7]; abs_s = ab; abd = w[7] && dr == 4'd2;
    end else if (w[15:10] == 6'b000100) begin
      cls = 2; opc = {1'b0, w[9:7]}; bw = w[6]; dm = w[5:4]; dr = w[3:0];
      ref_opnd(dr, dm, bw, sel, v, dx, inc, abd);
      ext = 0;
    end
    cnt = 2'(ext) + 2'(dx);
    r0 = ext ? 2'd1 : (dx ? 2'd2 : 2'd0);
    r1 = (ext && dx) ? 2'd2 : 2'd0;
    chk("R1", "class", 16'(out_class), 16'(cls), w);
    chk("R2/R3/R12", "opcode", 16'(out_opcode), 16'(opc), w);
    chk("R4", "cond", 16'(out_cond), 16'(cd), w);
    chk("R4", "offset", 16'(out_offset), 16'(of), w);
    chk("R2/R3", "byte", 16'(out_byte), 16'(bw), w);
    chk("R2/R3/R12", "sreg", 16'(out_sreg), 16'(sr), w);
    chk("R2/R3/R12", "dreg", 16'(out_dreg), 16'(dr), w);
    chk("R2/R3/R12", "smode", 16'(out_smode), 16'(sm), w);
    chk("R2/R3/R12", "dmode", 16'(out_dmode), 16'(dm), w);
    chk("R5/R6", "cg_sel", 16'(out_cg_sel), 16'(sel), w);
    chk("R5/R6", "cg_value", out_cg_value, v, w);
    chk("R6", "abs_src", 16'(out_abs_src), 16'(abs_s), w);
    chk("R6", "abs_dst", 16'(out_abs_dst), 16'(abd), w);
    chk("R7", "ext_count", 16'(out_ext_count), 16'(cnt), w);
    chk("R8", "ext0_role", 16'(out_ext0_role), 16'(r0), w);
    chk("R8", "ext1_role", 16'(out_ext1_role), 16'(r1), w);
    chk("R9", "inc_step", 16'(out_inc_step), 16'(inc), w);
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "out_valid", 16'(out_valid), 16'd1, w);
    check_word(w);
  endtask

  function automatic logic [15:0] rand_word();
    logic [15:0] w;
    logic [3:0] ra, rb;
    w  = 16'($urandom);
    ra = ($urandom % 2) ? 4'($urandom % 4) : w[11:8];
    rb = ($urandom % 2) ? 4'($urandom % 4) : w[3:0];
    case ($urandom % 4)
      0: w = {3'b001, w[12:0]};
      1: w = {6'b000100, w[9:4], rb};
      2: w = {w[15:14] == 2'b00 ? 2'b01 : w[15:14], w[13:12], ra, w[7:4], rb};
      default: w = {w[15:4], rb};
    endcase
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w1, w2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "out_valid", 16'(out_valid), 16'd0, 16'h0);
    chk("R11", "in_ready", 16'(in_ready), 16'd1, 16'h0);
    rst_n = 1'b1;

    // R5: zero register in every mode
    send(16'h4304); send(16'h4314); send(16'h4324); send(16'h4334);
    // R6: status register in every mode, and absolute destination
    send(16'h4204); send(16'h4214); send(16'h4224); send(16'h4234);
    send(16'h4582);
    // R7, R8: immediate source, both indexed, indexed dest only
    send(16'h4035); send(16'h4596); send(16'h4586); send(16'h4216);
    // R9: byte step, stack pointer step, word step
    send(16'h4474); send(16'h4174); send(16'h4434);
    // R3: single-operand words with constant, index and increment
    send(16'h1093); send(16'h1115); send(16'h1170); send(16'h1074);
    // R4, R1, R12: jumps and illegal words
    send(16'h2000); send(16'h3FFF); send(16'h0000); send(16'h1400);
    send(16'h0FFF); send(16'h1C35);

    for (int i = 0; i < 3000; i++) send(rand_word());

    // R10: stall with a second word waiting
    w1 = 16'h4596; w2 = 16'h4334;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_word = w1;
    @(negedge clk);
    in_word = w2;
    chk("R10", "in_ready stalled", 16'(in_ready), 16'd0, w1);
    @(negedge clk);
    chk("R10", "out_valid held", 16'(out_valid), 16'd1, w1);
    check_word(w1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_word(w2);
    @(negedge clk);
    chk("R10", "drained", 16'(out_valid), 16'd0, w2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule